// File: doc/BRIEF.md
# Two-Tier Masked Interrupt Aggregator

This block gathers interrupt sources for a processor core in two tiers. The lower tier is the peripheral tier. It holds a 32-bit pending register and a 32-bit mask register. Single-cycle event pulses set the pending bits. Software clears them by writing ones. Two DMA channel request lines drive their own pending bits directly, as levels.

The upper tier is the system tier. It has its own pending and mask registers. Only two system levels are populated:

- Level 24 carries the OR of every unmasked peripheral source.
- Level 30 carries a periodic-timer event. Software clears it through a separate timer status/control register.

The processor request vector is the system pending AND the system mask, held in a register. Software reaches all registers through a simple single-cycle register bus. Read data appears in the cycle after the request.

Top module: `irq_aggregator`

## Requirements
- R1: A one-cycle pulse on bit b of `periph_evt`, where b is not a DMA bit, sets peripheral pending bit b at the next clock edge. The bit stays set until software clears it.
- R2: A bus write to offset 0x944 clears each peripheral pending bit whose write-data bit is 1. Write-data bits of 0 leave their pending bits unchanged. If an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: The peripheral mask register at offset 0x948 is plain read/write.
- R4: System pending bit 24 is 1 exactly when (peripheral pending AND peripheral mask) is nonzero. It takes its new value at the same clock edge as the registers that feed it.
- R5: System pending at offset 0x010 is read-only, and writes to it change nothing. System mask at offset 0x014 is read/write. System pending bits other than 24 and 30 always read 0.
- R6: A `timer_evt` pulse sets system pending bit 30. A write to offset 0x240 with write-data bit 7 set clears bit 30. Such a write with bit 7 clear has no effect. If a pulse and a clear arrive in the same cycle, the bit ends up set.
- R7: Peripheral pending bit 21 follows the level of `dma_req[0]`, and bit 20 follows `dma_req[1]`, each one edge later. Software clears and event pulses on these two bits have no effect.
- R8: `cpu_irq` equals system pending AND system mask. It is registered and changes at the same edge as those registers.
- R9: A read request returns data on `bus_rdata` in the following cycle. Reads of unmapped offsets and of offset 0x240 return 0. `bus_rdata` is 0 in any cycle that follows no read. Writes to unmapped offsets change no register.
- R10: After reset every register is 0, including `cpu_irq` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read request |
| periph_evt | input | 32 | Peripheral event pulses, one bit per source |
| dma_req | input | 2 | DMA channel request levels |
| timer_evt | input | 1 | Periodic timer event pulse |
| cpu_irq | output | 32 | Masked system interrupt request vector |

## Verification
The assertions assume the following about the inputs:

- `periph_evt` and `timer_evt` are pulses sampled at the clock edge.
- Event bits on the DMA positions carry no meaning.
- `dma_req`, the event inputs and the bus stay low while reset is asserted. This keeps the one-cycle history checks meaningful from the first edge after reset.

The stimulus follows these rules:

- It drives all inputs only at falling edges.
- It holds each event for exactly one cycle.
- It keeps every input at zero during reset.
- It deliberately asserts event and clear together only to exercise the set-wins rule.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_SYS_PEND  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_SYS_MASK  = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_TMR_CTL   = 12'h240;
    localparam logic [ADDR_W-1:0] OFF_PER_PEND  = 12'h944;
    localparam logic [ADDR_W-1:0] OFF_PER_MASK  = 12'h948;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SYS_PEND,
        SEL_SYS_MASK,
        SEL_TMR_CTL,
        SEL_PER_PEND,
        SEL_PER_MASK
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] mask;
    } periph_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] irq;
    } sys_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

endpackage

// File: rtl/irq_bus_port.sv
module irq_bus_port
    import irq_agg_pkg::*;
#(
    parameter int TCLR_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] per_pend,
    input  logic [DATA_W-1:0] per_mask,
    input  logic [DATA_W-1:0] sys_pend,
    input  logic [DATA_W-1:0] sys_mask,
    output logic              per_clr_we,
    output logic              per_mask_we,
    output logic              sys_mask_we,
    output logic              tmr_clr_req,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_sel_e   sel;
    bus_state_t st_d, st_q;

    always_comb begin
        unique case (bus_addr)
            OFF_SYS_PEND: sel = SEL_SYS_PEND;
            OFF_SYS_MASK: sel = SEL_SYS_MASK;
            OFF_TMR_CTL:  sel = SEL_TMR_CTL;
            OFF_PER_PEND: sel = SEL_PER_PEND;
            OFF_PER_MASK: sel = SEL_PER_MASK;
            default:      sel = SEL_NONE;
        endcase
    end

    assign per_clr_we  = bus_valid && bus_write && (sel == SEL_PER_PEND);
    assign per_mask_we = bus_valid && bus_write && (sel == SEL_PER_MASK);
    assign sys_mask_we = bus_valid && bus_write && (sel == SEL_SYS_MASK);
    assign tmr_clr_req = bus_valid && bus_write && (sel == SEL_TMR_CTL)
                         && bus_wdata[TCLR_BIT];

    always_comb begin
        st_d = '0;
        if (bus_valid && !bus_write) begin
            case (sel)
                SEL_SYS_PEND: st_d.rdata = sys_pend;
                SEL_SYS_MASK: st_d.rdata = sys_mask;
                SEL_PER_PEND: st_d.rdata = per_pend;
                SEL_PER_MASK: st_d.rdata = per_mask;
                default:      st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/irq_periph_tier.sv
module irq_periph_tier
    import irq_agg_pkg::*;
#(
    parameter int                         DMA_CH  = 2,
    parameter int                         POS_W   = $clog2(DATA_W),
    parameter logic [DMA_CH*POS_W-1:0]    DMA_POS = {5'd20, 5'd21}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic [DMA_CH-1:0] dma_req,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pend,
    output logic [DATA_W-1:0] mask,
    output logic              any_d
);

    periph_state_t     st_d, st_q;
    logic [DATA_W-1:0] dma_bits;

    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_dma_map
            logic [DMA_CH-1:0] hit;
            for (genvar c = 0; c < DMA_CH; c++) begin : g_ch
                assign hit[c] = (DMA_POS[c*POS_W +: POS_W] == POS_W'(g));
            end
            assign dma_bits[g] = |hit;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        st_d.pend = (st_q.pend & ~(clr_we ? wdata : '0)) | (evt & ~dma_bits);
        for (int c = 0; c < DMA_CH; c++) begin
            st_d.pend[DMA_POS[c*POS_W +: POS_W]] = dma_req[c];
        end
        if (mask_we) st_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend  = st_q.pend;
    assign mask  = st_q.mask;
    assign any_d = |(st_d.pend & st_d.mask);

endmodule

// File: rtl/irq_sys_tier.sv
module irq_sys_tier
    import irq_agg_pkg::*;
#(
    parameter int PER_LVL = 24,
    parameter int TMR_LVL = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_any,
    input  logic              timer_evt,
    input  logic              tmr_clr,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pend,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] irq
);

    sys_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend          = '0;
        st_d.pend[PER_LVL] = per_any;
        st_d.pend[TMR_LVL] = timer_evt | (st_q.pend[TMR_LVL] & ~tmr_clr);
        if (mask_we) st_d.mask = wdata;
        st_d.irq = st_d.pend & st_d.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign mask = st_q.mask;
    assign irq  = st_q.irq;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int DMA_CH   = 2,
    parameter int PER_LVL  = 24,
    parameter int TMR_LVL  = 30,
    parameter int TCLR_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       periph_evt,
    input  logic [1:0]        dma_req,
    input  logic              timer_evt,
    output logic [31:0]       cpu_irq
);

    logic [DATA_W-1:0] ppend_w, pmask_w, spend_w, smask_w;
    logic              per_clr_we, per_mask_we, sys_mask_we, tmr_clr_req;
    logic              per_any_d;

    irq_bus_port #(.TCLR_BIT(TCLR_BIT)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .per_pend    (ppend_w),
        .per_mask    (pmask_w),
        .sys_pend    (spend_w),
        .sys_mask    (smask_w),
        .per_clr_we  (per_clr_we),
        .per_mask_we (per_mask_we),
        .sys_mask_we (sys_mask_we),
        .tmr_clr_req (tmr_clr_req),
        .bus_rdata   (bus_rdata)
    );

    irq_periph_tier #(.DMA_CH(DMA_CH)) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (periph_evt),
        .dma_req (dma_req),
        .clr_we  (per_clr_we),
        .mask_we (per_mask_we),
        .wdata   (bus_wdata),
        .pend    (ppend_w),
        .mask    (pmask_w),
        .any_d   (per_any_d)
    );

    irq_sys_tier #(.PER_LVL(PER_LVL), .TMR_LVL(TMR_LVL)) u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_any   (per_any_d),
        .timer_evt (timer_evt),
        .tmr_clr   (tmr_clr_req),
        .mask_we   (sys_mask_we),
        .wdata     (bus_wdata),
        .pend      (spend_w),
        .mask      (smask_w),
        .irq       (cpu_irq)
    );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] periph_evt,
    input logic [1:0]  dma_req,
    input logic        timer_evt,
    input logic [31:0] ppend,
    input logic [31:0] pmask,
    input logic [31:0] spend,
    input logic [31:0] smask,
    input logic [31:0] cpu_irq
);

    localparam logic [31:0] DMA_BITS = 32'h0030_0000;
    localparam logic [31:0] SYS_BITS = 32'h4100_0000;

    logic hist_q;
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= 1'b1;
    end

    wire       wr_pp   = bus_valid && bus_write && (bus_addr == 12'h944);
    wire       wr_tc   = bus_valid && bus_write && (bus_addr == 12'h240);
    wire [31:0] clr_ok = bus_wdata & ~periph_evt & ~DMA_BITS;
    wire [31:0] evt_ok = periph_evt & ~DMA_BITS;

    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ok != 0) |=> ((ppend & $past(evt_ok)) == $past(evt_ok)));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pp && clr_ok != 0) |=> ((ppend & $past(clr_ok)) == 0));

    assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spend[24] == (|(ppend & pmask)));

    assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spend & ~SYS_BITS) == 0);

    assert_tmr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tc && bus_wdata[7] && !timer_evt) |=> !spend[30]);

    assert_dma_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hist_q |-> (ppend[21] == $past(dma_req[0]) && ppend[20] == $past(dma_req[1])));

    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (spend & smask));

endmodule

bind irq_aggregator irq_agg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .periph_evt (periph_evt),
    .dma_req    (dma_req),
    .timer_evt  (timer_evt),
    .ppend      (ppend_w),
    .pmask      (pmask_w),
    .spend      (spend_w),
    .smask      (smask_w),
    .cpu_irq    (cpu_irq)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] periph_evt = '0;
    logic [1:0]  dma_req = '0;
    logic        timer_evt = 1'b0;
    logic [31:0] cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .periph_evt (periph_evt),
        .dma_req    (dma_req),
        .timer_evt  (timer_evt),
        .cpu_irq    (cpu_irq)
    );

    // behavioural reference model
    logic [31:0] m_pp = '0, m_pm = '0, m_sp = '0, m_sm = '0, m_irq = '0, m_rd = '0;

    always @(posedge clk) begin
        logic [31:0] pp, pm, sp, sm, rd;
        if (!rst_n) begin
            m_pp = '0; m_pm = '0; m_sp = '0; m_sm = '0; m_irq = '0; m_rd = '0;
        end else begin
            rd = 32'h0;
            if (bus_valid && !bus_write) begin
                if (bus_addr == 12'h010) rd = m_sp;
                else if (bus_addr == 12'h014) rd = m_sm;
                else if (bus_addr == 12'h944) rd = m_pp;
                else if (bus_addr == 12'h948) rd = m_pm;
            end
            pp = m_pp;
            if (bus_valid && bus_write && bus_addr == 12'h944) pp = pp & ~bus_wdata;
            pp = pp | periph_evt;
            pp[21] = dma_req[0];
            pp[20] = dma_req[1];
            pm = (bus_valid && bus_write && bus_addr == 12'h948) ? bus_wdata : m_pm;
            sm = (bus_valid && bus_write && bus_addr == 12'h014) ? bus_wdata : m_sm;
            sp = 32'h0;
            sp[24] = ((pp & pm) != 0);
            sp[30] = timer_evt ||
                     (m_sp[30] && !(bus_valid && bus_write && bus_addr == 12'h240 && bus_wdata[7]));
            m_pp = pp; m_pm = pm; m_sp = sp; m_sm = sm; m_rd = rd;
            m_irq = sp & sm;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 cpu_irq vs model", cpu_irq, m_irq);
            chk("R9 rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [31:0] e, input logic t);
        periph_evt = e; timer_evt = t;
        @(posedge clk); @(negedge clk);
        periph_evt = '0; timer_evt = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset cpu_irq", cpu_irq, 32'h0);
        chk("R10 reset rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h944, 32'h0, "R10 per pend after reset");
        rd(12'h014, 32'h0, "R10 sys mask after reset");

        // R3 peripheral mask
        wr(12'h948, 32'hFFFF_0000);
        rd(12'h948, 32'hFFFF_0000, "R3 per mask readback");

        // R1 events set pending
        pulse(32'h4000_0008, 1'b0);
        @(negedge clk);
        rd(12'h944, 32'h4000_0008, "R1 events latched");
        rd(12'h010, 32'h0100_0000, "R4 level 24 set");
        chk("R8 masked by sys mask", cpu_irq, 32'h0);

        // R5 system mask / read-only pending
        wr(12'h014, 32'hFFFF_FFFF);
        rd(12'h014, 32'hFFFF_FFFF, "R5 sys mask readback");
        chk("R8 irq level 24", cpu_irq, 32'h0100_0000);
        wr(12'h010, 32'h0);
        rd(12'h010, 32'h0100_0000, "R5 sys pend read-only");

        // R2 write-one-to-clear
        wr(12'h944, 32'h4000_0000);
        rd(12'h944, 32'h0000_0008, "R2 selective clear");
        rd(12'h010, 32'h0, "R4 level 24 drops");
        chk("R8 irq cleared", cpu_irq, 32'h0);

        // R2 set wins over clear in same cycle
        periph_evt = 32'h0000_0010;
        wr(12'h944, 32'h0000_0010);
        periph_evt = '0;
        rd(12'h944, 32'h0000_0018, "R2 set wins");
        wr(12'h944, 32'h0000_0018);
        rd(12'h944, 32'h0, "R2 full clear");

        // R6 timer level
        pulse(32'h0, 1'b1);
        chk("R6 timer irq", cpu_irq, 32'h4000_0000);
        wr(12'h240, 32'h0000_007F);
        chk("R6 clear without bit7 ignored", cpu_irq, 32'h4000_0000);
        wr(12'h240, 32'h0000_0080);
        chk("R6 timer cleared", cpu_irq, 32'h0);
        timer_evt = 1'b1;
        wr(12'h240, 32'h0000_0080);
        timer_evt = 1'b0;
        rd(12'h010, 32'h4000_0000, "R6 set wins");
        wr(12'h240, 32'h0000_0080);

        // R7 DMA levels
        dma_req = 2'b01;
        @(negedge clk);
        chk("R7 dma0 raises level 24", cpu_irq, 32'h0100_0000);
        wr(12'h944, 32'h0020_0000);
        rd(12'h944, 32'h0020_0000, "R7 clear of dma bit ignored");
        dma_req = 2'b10;
        @(negedge clk);
        rd(12'h944, 32'h0010_0000, "R7 dma1 bit follows");
        dma_req = 2'b00;
        pulse(32'h0030_0000, 1'b0);
        rd(12'h944, 32'h0, "R7 events on dma bits ignored");
        chk("R7 irq idle", cpu_irq, 32'h0);

        // R9 unmapped offsets
        rd(12'h123, 32'h0, "R9 unmapped read");
        rd(12'h240, 32'h0, "R9 timer ctl reads zero");
        wr(12'h94C, 32'hFFFF_FFFF);
        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h948, 32'hFFFF_0000, "R9 per mask untouched");
        rd(12'h014, 32'hFFFF_FFFF, "R9 sys mask untouched");
        rd(12'h944, 32'h0, "R9 per pend untouched");
        @(negedge clk);
        chk("R9 rdata idle zero", bus_rdata, 32'h0);

        finish_run();
    end

endmodule